// File: doc/BRIEF.md
# Dual-Clock FIFO with Switchable Flag Conventions

This block is a first-in first-out buffer with independent write and read clocks. It has a static mode input that selects one of two conventions for the same pins. In standard mode the two main status pins are an active-low full flag and an active-low empty flag, and a word appears on the read data only after a read. In fall-through mode the pins become input-ready and output-ready. The first stored word moves to the read data without any read, and that output register adds one word to the capacity.

Two programmable status pins warn before the buffer fills or drains. The thresholds come from two offset inputs. A second static input selects when these pins change. With synchronous timing, each pin follows one clock. With asynchronous timing, each pin is asserted by the edge of one clock and released by the edge of the other. Write and read pointers cross between the clock domains as Gray code through two-flop synchronizers. A flag that depends on the other domain can therefore lag by up to three cycles of its own clock. Change the mode, timing and offset inputs only while reset is held.

Top module: `dual_mode_fifo`

## Requirements
- R1: While rst_n is low and right after it rises, paf_n is 1 and pae_n is 0. full_ir reads 1 in standard mode and 0 in fall-through mode. empty_or reads 0 in standard mode and 1 in fall-through mode.
- R2: In standard mode (fwft=0), full_ir falls to 0 at the write-clock edge of the D-th write when no reads occur (D = 2^AW). A write while full_ir is 0 stores nothing and moves no pointer.
- R3: In fall-through mode (fwft=1), full_ir rises to 1 at the write edge that brings the total held, counting the output register, to D+1. A write while full_ir is 1 stores nothing.
- R4: In standard mode, empty_or is 0 whenever no word is held. A read (ren_n=0) while empty_or is 0 leaves rdata unchanged and consumes nothing.
- R5: In fall-through mode, the oldest word appears on rdata together with empty_or going to 0, with no read needed. It stays while ren_n is 1. After a read of the last word, empty_or returns to 1 and rdata keeps that last word.
- R6: Words leave in the order they were accepted, without loss or duplication, under any mix of reads and writes.
- R7: With async_flags=0, paf_n is 0 exactly when the total held is at least D-m (standard) or D+1-m (fall-through), where m is full_ofs. It updates on write-clock edges.
- R8: With async_flags=0, pae_n is 0 exactly when the total held is at most n (standard) or n+1 (fall-through), where n is empty_ofs. It updates on read-clock edges.
- R9: With async_flags=1, paf_n falls at the write edge that brings the total to the R7 threshold. It rises at the read edge that drops the total below that threshold.
- R10: With async_flags=1, pae_n falls at the read edge that leaves the total at or below the R8 threshold. It rises at the write edge that lifts the total above it.
- R11: Each pointer changes at most one bit of its Gray code per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset for both domains, active low |
| fwft | input | 1 | 0 selects standard mode, 1 selects fall-through mode |
| async_flags | input | 1 | 1 selects two-clock timing for the programmable flags |
| full_ofs | input | AW+1 | Almost-full offset m |
| empty_ofs | input | AW+1 | Almost-empty offset n |
| wclk | input | 1 | Write clock |
| wen_n | input | 1 | Write enable, active low |
| wdata | input | DW | Write data |
| full_ir | output | 1 | Full flag (low = full) or input-ready (high = no room) |
| rclk | input | 1 | Read clock |
| ren_n | input | 1 | Read enable, active low |
| rdata | output | DW | Read data |
| empty_or | output | 1 | Empty flag (low = empty) or output-ready (low = word valid) |
| paf_n | output | 1 | Almost-full flag, active low |
| pae_n | output | 1 | Almost-empty flag, active low |

## Verification
In fall-through mode, one read-clock edge can both consume the word on the output register and reload it from memory. On the same edge, an almost-empty assertion can be due. A random phase holds both enables active much of the time so these meet, and a reference queue judges every presented word. Writes that arrive at the full boundary while reads drain the buffer are provoked the same way: the writer is biased toward writing early and the reader toward reading late. Each write is counted as accepted only if the full indication seen just before its edge allowed it.

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
  parameter int DW = 18,
  parameter int AW = 4
) (
  input  logic          rst_n,
  input  logic          fwft,
  input  logic          async_flags,
  input  logic [AW:0]   full_ofs,
  input  logic [AW:0]   empty_ofs,
  input  logic          wclk,
  input  logic          wen_n,
  input  logic [DW-1:0] wdata,
  output logic          full_ir,
  input  logic          rclk,
  input  logic          ren_n,
  output logic [DW-1:0] rdata,
  output logic          empty_or,
  output logic          paf_n,
  output logic          pae_n
);

  localparam int D  = 1 << AW;
  localparam int PW = AW + 1;
  localparam int CW = AW + 2;
  localparam logic [CW-1:0] DEP = CW'(D);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [DW-1:0] mem [0:D-1];

  // write domain
  logic [PW-1:0] wbin, wgray, rq1, rq2;
  logic          full_q, pafw_q, af_s, ae_c, afc1, afc2, aes1, aes2;
  // read domain
  logic [PW-1:0] rbin, rgray, wq1, wq2;
  logic          emp_q, ov, paer_q, af_c, ae_s, afs1, afs2, aec1, aec2;

  logic          wr_ok, w_full, w_af, w_ne;
  logic [PW-1:0] wbin_nx, wcnt;

  assign wr_ok   = ~wen_n & ~full_q;
  assign wbin_nx = wbin + PW'(wr_ok);
  assign wcnt    = wbin_nx - g2b(rq2);
  assign w_full  = (wcnt == PW'(D));
  assign w_af    = ({1'b0, wcnt} + {1'b0, full_ofs}) >= DEP;
  assign w_ne    = wcnt > empty_ofs;

  always_ff @(posedge wclk)
    if (wr_ok) mem[wbin[AW-1:0]] <= wdata;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      rq1    <= '0;
      rq2    <= '0;
      full_q <= 1'b0;
      pafw_q <= 1'b0;
      af_s   <= 1'b0;
      ae_c   <= 1'b0;
      afc1   <= 1'b0;
      afc2   <= 1'b0;
      aes1   <= 1'b1;
      aes2   <= 1'b1;
    end else begin
      wbin   <= wbin_nx;
      wgray  <= b2g(wbin_nx);
      rq1    <= rgray;
      rq2    <= rq1;
      full_q <= w_full;
      pafw_q <= w_af;
      afc1   <= af_c;
      afc2   <= afc1;
      aes1   <= ae_s;
      aes2   <= aes1;
      if (wr_ok && w_af && (af_s == afc2)) af_s <= ~af_s;
      if (wr_ok && w_ne && (ae_c != aes2)) ae_c <= ~ae_c;
    end
  end

  logic          pop, ov_nx, rd_evt, r_emp, r_ae, r_af;
  logic [PW-1:0] rbin_nx, rcnt;

  assign pop     = ~emp_q & (fwft ? (~ov | ~ren_n) : ~ren_n);
  assign ov_nx   = fwft & (pop | (ov & ren_n));
  assign rd_evt  = pop | (fwft & ov & ~ren_n);
  assign rbin_nx = rbin + PW'(pop);
  assign rcnt    = g2b(wq2) - rbin_nx;
  assign r_emp   = (rcnt == '0);
  assign r_ae    = ({1'b0, rcnt} + CW'(ov_nx)) <= ({1'b0, empty_ofs} + CW'(fwft));
  assign r_af    = ({1'b0, rcnt} + {1'b0, full_ofs}) >= DEP;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin   <= '0;
      rgray  <= '0;
      wq1    <= '0;
      wq2    <= '0;
      emp_q  <= 1'b1;
      ov     <= 1'b0;
      paer_q <= 1'b1;
      af_c   <= 1'b0;
      ae_s   <= 1'b1;
      afs1   <= 1'b0;
      afs2   <= 1'b0;
      aec1   <= 1'b0;
      aec2   <= 1'b0;
      rdata  <= '0;
    end else begin
      rbin   <= rbin_nx;
      rgray  <= b2g(rbin_nx);
      wq1    <= wgray;
      wq2    <= wq1;
      emp_q  <= r_emp;
      ov     <= ov_nx;
      paer_q <= r_ae;
      afs1   <= af_s;
      afs2   <= afs1;
      aec1   <= ae_c;
      aec2   <= aec1;
      if (pop) rdata <= mem[rbin[AW-1:0]];
      if (pop && !r_af && (af_c != afs2)) af_c <= ~af_c;
      if (rd_evt && r_ae && (ae_s == aec2)) ae_s <= ~ae_s;
    end
  end

  assign full_ir  = fwft ? full_q : ~full_q;
  assign empty_or = fwft ? ~ov : ~emp_q;
  assign paf_n    = ~(async_flags ? (af_s ^ af_c) : pafw_q);
  assign pae_n    = ~(async_flags ? (ae_s ^ ae_c) : paer_q);

endmodule

// File: rtl/dual_mode_fifo_chk.sv
module dual_mode_fifo_chk #(
  parameter int DW = 18,
  parameter int AW = 4
) (
  input logic          rst_n,
  input logic          wclk,
  input logic          rclk,
  input logic          fwft,
  input logic          wen_n,
  input logic          ren_n,
  input logic          full_ir,
  input logic          empty_or,
  input logic [DW-1:0] rdata,
  input logic [AW:0]   wbin,
  input logic [AW:0]   rbin,
  input logic [AW:0]   wgray,
  input logic [AW:0]   rgray
);

  a_r2_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
    (!fwft && !full_ir && !wen_n) |=> $stable(wbin));

  a_r3_no_overflow_ff: assert property (@(posedge wclk) disable iff (!rst_n)
    (fwft && full_ir && !wen_n) |=> $stable(wbin));

  a_r4_no_underflow: assert property (@(posedge rclk) disable iff (!rst_n)
    (!fwft && !empty_or && !ren_n) |=> ($stable(rbin) && $stable(rdata)));

  a_r5_word_held: assert property (@(posedge rclk) disable iff (!rst_n)
    (fwft && !empty_or && ren_n) |=> ($stable(rdata) && !empty_or));

  a_r11_wgray_step: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  a_r11_rgray_step: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);

endmodule

bind dual_mode_fifo dual_mode_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
  .rst_n(rst_n), .wclk(wclk), .rclk(rclk), .fwft(fwft),
  .wen_n(wen_n), .ren_n(ren_n), .full_ir(full_ir), .empty_or(empty_or),
  .rdata(rdata), .wbin(wbin), .rbin(rbin), .wgray(wgray), .rgray(rgray)
);

// File: tb/test_dual_mode_fifo.sv
module test_dual_mode_fifo;
  localparam int DW = 18;
  localparam int AW = 4;
  localparam int D  = 1 << AW;

  logic wclk = 0, rclk = 0, rst_n = 0, fwft = 0, async_flags = 0;
  logic wen_n = 1, ren_n = 1;
  logic [AW:0] full_ofs = '0, empty_ofs = '0;
  logic [DW-1:0] wdata = '0;
  logic full_ir, empty_or, paf_n, pae_n;
  logic [DW-1:0] rdata;

  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] q[$];

  dual_mode_fifo #(.DW(DW), .AW(AW)) i_dual_mode_fifo (
    .rst_n(rst_n), .fwft(fwft), .async_flags(async_flags),
    .full_ofs(full_ofs), .empty_ofs(empty_ofs),
    .wclk(wclk), .wen_n(wen_n), .wdata(wdata), .full_ir(full_ir),
    .rclk(rclk), .ren_n(ren_n), .rdata(rdata), .empty_or(empty_or),
    .paf_n(paf_n), .pae_n(pae_n)
  );

  function automatic bit exp_full(int t, bit fw);
    return t >= D + int'(fw);
  endfunction
  function automatic bit exp_af(int t, bit fw, int m);
    return t >= D + int'(fw) - m;
  endfunction
  function automatic bit exp_ae(int t, bit fw, int n);
    return t <= n + int'(fw);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reset_to(input bit fw, input bit as, input int m, input int n);
    @(negedge wclk);
    rst_n = 0; wen_n = 1; ren_n = 1;
    fwft = fw; async_flags = as;
    full_ofs = (AW+1)'(m); empty_ofs = (AW+1)'(n);
    q.delete();
    repeat (3) @(negedge wclk);
    rst_n = 1;
    repeat (2) @(negedge rclk);
  endtask

  task automatic push(input logic [DW-1:0] d);
    bit acc;
    @(negedge wclk);
    acc = fwft ? !full_ir : full_ir;
    wen_n = 0; wdata = d;
    @(negedge wclk);
    wen_n = 1;
    if (acc) q.push_back(d);
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
    repeat (8) @(negedge wclk);
  endtask

  task automatic pop_std();
    bit ne;
    logic [DW-1:0] e;
    @(negedge rclk);
    ne = empty_or;
    ren_n = 0;
    @(negedge rclk);
    ren_n = 1;
    if (ne) begin
      e = q.pop_front();
      check("R6 std order", 32'(rdata), 32'(e));
    end
  endtask

  task automatic pop_fw();
    logic [DW-1:0] e;
    @(negedge rclk);
    if (!empty_or && q.size() > 0) begin
      e = q.pop_front();
      check("R6 fwft order", 32'(rdata), 32'(e));
    end
    ren_n = 0;
    @(negedge rclk);
    ren_n = 1;
  endtask

  task automatic check_reset(input bit fw);
    check("R1 full_ir", 32'(full_ir), fw ? 32'd0 : 32'd1);
    check("R1 empty_or", 32'(empty_or), fw ? 32'd1 : 32'd0);
    check("R1 paf_n", 32'(paf_n), 32'd1);
    check("R1 pae_n", 32'(pae_n), 32'd0);
  endtask

  task automatic rand_run(input bit fw);
    reset_to(fw, 0, 3, 3);
    fork
      begin
        for (int i = 0; i < 700; i++) begin
          @(negedge wclk);
          wen_n = ($urandom_range(0, 9) < ((i < 350) ? 8 : 3)) ? 1'b0 : 1'b1;
          wdata = DW'($urandom);
          if (!wen_n && (fwft ? !full_ir : full_ir)) q.push_back(wdata);
        end
        @(negedge wclk);
        wen_n = 1;
      end
      begin
        bit pend = 0;
        logic [DW-1:0] e = '0;
        for (int i = 0; i < 600; i++) begin
          @(negedge rclk);
          if (!fw) begin
            if (pend) check("R6 random std", 32'(rdata), 32'(e));
            ren_n = ($urandom_range(0, 9) < ((i < 250) ? 3 : 8)) ? 1'b0 : 1'b1;
            pend = !ren_n && empty_or;
            if (pend) begin
              if (q.size() > 0) e = q.pop_front();
              else check("R6 random std underrun", 32'd1, 32'd0);
            end
          end else begin
            ren_n = ($urandom_range(0, 9) < ((i < 250) ? 3 : 8)) ? 1'b0 : 1'b1;
            if (!empty_or) begin
              if (q.size() > 0) begin
                check("R6 random fwft", 32'(rdata), 32'(q[0]));
                if (!ren_n) void'(q.pop_front());
              end else check("R6 random fwft underrun", 32'd1, 32'd0);
            end
          end
        end
        @(negedge rclk);
        if (!fw && pend) check("R6 random std", 32'(rdata), 32'(e));
        ren_n = 1;
      end
    join
  endtask

  initial begin
    logic [DW-1:0] last;
    void'($urandom(32'h5eed_0042));

    // standard mode, synchronous flags
    reset_to(0, 0, 3, 2);
    check_reset(0);
    for (int k = 1; k <= D; k++) begin
      push(DW'(100 + k));
      check("R2 full flag", 32'(full_ir), 32'(!exp_full(k, 0)));
      check("R7 almost full std", 32'(paf_n), 32'(!exp_af(k, 0, 3)));
    end
    push(DW'(18'h3ffff));
    check("R2 write ignored while full", 32'(full_ir), 32'd0);
    settle();
    check("R4 not empty", 32'(empty_or), 32'd1);
    check("R8 almost empty std", 32'(pae_n), 32'd1);
    for (int t = D - 1; t >= 0; t--) begin
      pop_std();
      check("R8 almost empty std", 32'(pae_n), 32'(!exp_ae(t, 0, 2)));
    end
    check("R2 only D words kept", 32'(q.size()), 32'd0);
    check("R4 empty flag", 32'(empty_or), 32'd0);
    last = rdata;
    pop_std();
    check("R4 read when empty", 32'(rdata), 32'(last));
    push(DW'(55));
    settle();
    pop_std();
    check("R4 nothing consumed", 32'(q.size()), 32'd0);

    // fall-through mode, synchronous flags
    reset_to(1, 0, 2, 3);
    check_reset(1);
    push(DW'(200));
    settle();
    check("R5 output ready", 32'(empty_or), 32'd0);
    check("R5 word falls through", 32'(rdata), 32'd200);
    repeat (5) @(negedge rclk);
    check("R5 word held", 32'(rdata), 32'd200);
    for (int k = 2; k <= D + 1; k++) begin
      push(DW'(200 + k));
      check("R3 input ready", 32'(full_ir), 32'(exp_full(k, 1)));
      check("R7 almost full fwft", 32'(paf_n), 32'(!exp_af(k, 1, 2)));
    end
    push(DW'(18'h2aaaa));
    check("R3 write ignored while full", 32'(full_ir), 32'd1);
    settle();
    check("R8 almost empty fwft", 32'(pae_n), 32'd1);
    for (int t = D; t >= 0; t--) begin
      pop_fw();
      check("R8 almost empty fwft", 32'(pae_n), 32'(!exp_ae(t, 1, 3)));
    end
    check("R3 only D+1 words kept", 32'(q.size()), 32'd0);
    check("R5 output not ready", 32'(empty_or), 32'd1);
    check("R5 last word stays", 32'(rdata), 32'(200 + D + 1));
    pop_fw();
    check("R5 read inhibited", 32'(rdata), 32'(200 + D + 1));

    // standard mode, two-clock flags
    reset_to(0, 1, 4, 3);
    check_reset(0);
    for (int k = 1; k <= D; k++) begin
      push(DW'(300 + k));
      check("R9 almost full set on write", 32'(paf_n), 32'(!exp_af(k, 0, 4)));
      check("R10 almost empty cleared on write", 32'(pae_n), 32'(!exp_ae(k, 0, 3)));
    end
    settle();
    for (int t = D - 1; t >= 0; t--) begin
      pop_std();
      check("R9 almost full cleared on read", 32'(paf_n), 32'(!exp_af(t, 0, 4)));
      check("R10 almost empty set on read", 32'(pae_n), 32'(!exp_ae(t, 0, 3)));
    end

    // fall-through mode, two-clock flags
    reset_to(1, 1, 3, 2);
    check_reset(1);
    push(DW'(400));
    settle();
    for (int k = 2; k <= D + 1; k++) begin
      push(DW'(400 + k));
      check("R9 fwft almost full set", 32'(paf_n), 32'(!exp_af(k, 1, 3)));
      check("R10 fwft almost empty cleared", 32'(pae_n), 32'(!exp_ae(k, 1, 2)));
    end
    settle();
    for (int t = D; t >= 0; t--) begin
      pop_fw();
      check("R9 fwft almost full cleared", 32'(paf_n), 32'(!exp_af(t, 1, 3)));
      check("R10 fwft almost empty set", 32'(pae_n), 32'(!exp_ae(t, 1, 2)));
    end

    rand_run(0);
    rand_run(1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule